// File: doc/BRIEF.md
# USB Host Command Register with Interrupt Moderation

This block is the command register of a USB 2.0 host controller, together with its status bit and an interrupt moderation timer. Software reaches it through a single-cycle write/read port with two selectable words: the command word and the status word. The command word holds three things: the two schedule enable levels, an 8-bit interrupt threshold, and the async-advance doorbell.

Software rings the doorbell to ask the schedule engine to release its cached asynchronous state. When the engine reports that it has done so, the block posts the advance status bit. The doorbell clears itself one cycle after that. The status is not signalled immediately. A down-counter, driven by the 125 µs micro-frame tick, defines interrupt boundaries every 1 to 64 micro-frames. The interrupt line rises only at such a boundary, and it stays high until software clears the status bit.

Top module: `usbh_cmd_reg`

## Requirements
- R1: After a synchronous reset, the command word reads 0x00080000, the status word reads 0, and `irq`, `async_en` and `periodic_en` are 0.
- R2: Command bits 23:16 hold the interrupt threshold. It is written and read back unchanged, including values that are not valid.
- R3: Command bit 5 drives `async_en` and command bit 4 drives `periodic_en`. Both are read/write.
- R4: Command bits 31:24 and 15:7 read 0, and so do bits 3:0. Status bits other than bit 5 read 0. This holds whatever was written.
- R5: Writing 1 to command bit 6 sets the doorbell, and writing 0 there does not clear it. An `adv_done` pulse seen while both the doorbell and the async enable are 1 sets the status bit. The doorbell then clears one cycle later.
- R6: A doorbell that is set while the async enable is 0 clears on the next cycle, and it never sets the status bit.
- R7: An `adv_done` pulse does not change the status bit when no doorbell is pending.
- R8: Writing 1 to status bit 5 clears the status bit. If a status set and a clear fall in the same cycle, the set wins.
- R9: A boundary occurs on the tick on which the moderation counter reaches 1. The counter then reloads with the threshold: 1, 2, 4, 8, 16, 32 or 64 micro-frames for the one-hot values 01h to 40h, and 8 for any other value.
- R10: A new threshold takes effect only at the reload after the interval that is already running.
- R11: `irq` rises only at a boundary where the status bit and `irq_en` are both 1. It then stays high until the status bit is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | 0 selects the command word, 1 selects the status word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered readback of the selected word, taken at the clock edge |
| uframe_tick | input | 1 | One-cycle pulse per micro-frame |
| adv_done | input | 1 | Pulse from the schedule engine: cached async state has been released |
| irq_en | input | 1 | Enable for the async-advance interrupt |
| async_en | output | 1 | Async schedule enable level |
| periodic_en | output | 1 | Periodic schedule enable level |
| adv_status | output | 1 | Async-advance status bit |
| irq | output | 1 | Moderated interrupt line |

## Verification
Some behaviours are checked by the assertions on every cycle:
- a qualified `adv_done` posts the status on the following cycle;
- a pending doorbell holds until the status is posted, or drops when the async enable is 0;
- the status bit never rises without a pending doorbell;
- the moderation counter stays within its legal range;
- `irq` rises only at a qualified boundary and holds until the status is cleared.

Other behaviours only the bench scenarios can show, because they depend on long sequences of ticks:
- the exact boundary spacing for each threshold, and the fallback to 8 for an invalid value;
- the delayed effect of a threshold change;
- the absence of an interrupt while `irq_en` is 0.

// File: rtl/usbh_cmd_pkg.sv
package usbh_cmd_pkg;
  // Command word bit positions that software decodes
  localparam int DOOR_BIT = 6;
  localparam int ASE_BIT  = 5;
  localparam int PSE_BIT  = 4;
  // Status word bit position of the async-advance status
  localparam int STS_BIT  = 5;
endpackage

// File: rtl/usbh_cmd_regfile.sv
module usbh_cmd_regfile
  import usbh_cmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int THR_W   = 8,
  parameter int THR_LSB = 16,
  parameter int DEF_THR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              sts_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              adv_done,
  output logic [THR_W-1:0]  thr_o,
  output logic              ase_o,
  output logic              pse_o,
  output logic              door_o,
  output logic              sts_o,
  output logic              sts_clr_o
);
  logic [THR_W-1:0] thr_q;
  logic ase_q, pse_q, door_q, clrp_q, sts_q;
  logic adv_hit, sts_clr;

  assign adv_hit = adv_done && door_q && ase_q;
  assign sts_clr = sts_wr && wdata[STS_BIT] && !adv_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= THR_W'(DEF_THR);
      ase_q  <= 1'b0;
      pse_q  <= 1'b0;
      door_q <= 1'b0;
      clrp_q <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      if (cmd_wr) begin
        thr_q <= wdata[THR_LSB +: THR_W];
        ase_q <= wdata[ASE_BIT];
        pse_q <= wdata[PSE_BIT];
      end
      clrp_q <= adv_hit;
      if (cmd_wr && wdata[DOOR_BIT]) door_q <= 1'b1;
      else if (clrp_q || !ase_q)     door_q <= 1'b0;
      if (adv_hit)      sts_q <= 1'b1;
      else if (sts_clr) sts_q <= 1'b0;
    end
  end

  assign thr_o     = thr_q;
  assign ase_o     = ase_q;
  assign pse_o     = pse_q;
  assign door_o    = door_q;
  assign sts_o     = sts_q;
  assign sts_clr_o = sts_clr;

  // R5
  adv_set_chk: assert property (@(posedge clk) disable iff (rst)
    adv_hit |=> sts_q);
  // R5
  door_hold_chk: assert property (@(posedge clk) disable iff (rst)
    door_q && ase_q && !clrp_q |=> door_q);
  // R6
  door_drop_chk: assert property (@(posedge clk) disable iff (rst)
    door_q && !ase_q && !(cmd_wr && wdata[DOOR_BIT]) |=> !door_q);
  // R7
  sts_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q) |-> $past(door_q && ase_q));
  // R8
  sts_clr_chk: assert property (@(posedge clk) disable iff (rst)
    sts_clr |=> !sts_q);
endmodule

// File: rtl/usbh_irq_moderator.sv
module usbh_irq_moderator #(
  parameter int THR_W   = 8,
  parameter int MAX_LOG = 6,
  parameter int DEF_THR = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [THR_W-1:0] thr,
  input  logic             sts,
  input  logic             sts_clr,
  input  logic             irq_en,
  output logic             irq_o
);
  localparam int CNT_W   = MAX_LOG + 1;
  localparam int MAX_INT = 1 << MAX_LOG;

  logic [MAX_LOG:0] hit;
  logic [CNT_W-1:0] eff, cnt_q;
  logic             boundary, irq_q;

  // One comparator per legal interval
  for (genvar i = 0; i <= MAX_LOG; i++) begin : g_legal
    assign hit[i] = (thr == THR_W'(1 << i));
  end

  always_comb begin
    eff = CNT_W'(DEF_THR);
    for (int i = 0; i <= MAX_LOG; i++)
      if (hit[i]) eff = CNT_W'(1 << i);
  end

  assign boundary = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(DEF_THR);
      irq_q <= 1'b0;
    end else begin
      if (tick) cnt_q <= boundary ? eff : cnt_q - CNT_W'(1);
      if (sts_clr)                          irq_q <= 1'b0;
      else if (boundary && sts && irq_en)   irq_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) && (cnt_q <= CNT_W'(MAX_INT)));
  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(boundary && sts && irq_en));
  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q && !sts_clr |=> irq_q);
endmodule

// File: rtl/usbh_cmd_reg.sv
module usbh_cmd_reg
  import usbh_cmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int THR_W   = 8,
  parameter int THR_LSB = 16,
  parameter int MAX_LOG = 6,
  parameter int DEF_THR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              uframe_tick,
  input  logic              adv_done,
  input  logic              irq_en,
  output logic              async_en,
  output logic              periodic_en,
  output logic              adv_status,
  output logic              irq
);
  logic [THR_W-1:0]  thr;
  logic              door, sts, sts_clr;
  logic [DATA_W-1:0] cmd_word, sts_word;

  usbh_cmd_regfile #(
    .DATA_W(DATA_W), .THR_W(THR_W), .THR_LSB(THR_LSB), .DEF_THR(DEF_THR)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cmd_wr(wr_en && !reg_sel), .sts_wr(wr_en && reg_sel),
    .wdata(wdata), .adv_done(adv_done),
    .thr_o(thr), .ase_o(async_en), .pse_o(periodic_en),
    .door_o(door), .sts_o(sts), .sts_clr_o(sts_clr)
  );

  usbh_irq_moderator #(
    .THR_W(THR_W), .MAX_LOG(MAX_LOG), .DEF_THR(DEF_THR)
  ) u_mod (
    .clk(clk), .rst(rst), .tick(uframe_tick), .thr(thr),
    .sts(sts), .sts_clr(sts_clr), .irq_en(irq_en), .irq_o(irq)
  );

  always_comb begin
    cmd_word                   = '0;
    cmd_word[THR_LSB +: THR_W] = thr;
    cmd_word[DOOR_BIT]         = door;
    cmd_word[ASE_BIT]          = async_en;
    cmd_word[PSE_BIT]          = periodic_en;
    sts_word                   = '0;
    sts_word[STS_BIT]          = sts;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= reg_sel ? sts_word : cmd_word;
  end

  assign adv_status = sts;
endmodule

// File: tb/usbh_cmd_reg_bench.sv
module usbh_cmd_reg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, reg_sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        uframe_tick = 1'b0, adv_done = 1'b0, irq_en = 1'b0;
  logic        async_en, periodic_en, adv_status, irq;

  int n_chk = 0, n_fail = 0;

  // Reference model state
  int          m_thr = 8, m_cnt = 8;
  bit          m_ase, m_pse, m_door, m_clrp, m_sts, m_irq;
  logic [31:0] m_rd = '0;

  always #10 clk = ~clk;

  usbh_cmd_reg u_usbh_cmd_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rdata), .uframe_tick(uframe_tick), .adv_done(adv_done),
    .irq_en(irq_en), .async_en(async_en), .periodic_en(periodic_en),
    .adv_status(adv_status), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_cmd();
    return (32'(m_thr & 255) << 16) | (32'(m_door) << 6) |
           (32'(m_ase) << 5) | (32'(m_pse) << 4);
  endfunction

  task automatic model_step();
    bit hit, clr, cw, bnd;
    int eff;
    if (rst) begin
      m_thr = 8; m_cnt = 8; m_ase = 0; m_pse = 0; m_door = 0;
      m_clrp = 0; m_sts = 0; m_irq = 0; m_rd = '0;
      return;
    end
    hit = adv_done && m_door && m_ase;
    clr = wr_en && reg_sel && wdata[5] && !hit;
    cw  = wr_en && !reg_sel;
    bnd = uframe_tick && (m_cnt == 1);
    eff = (m_thr inside {1, 2, 4, 8, 16, 32, 64}) ? m_thr : 8;
    m_rd = reg_sel ? (m_sts ? 32'h20 : 32'h0) : m_cmd();
    if (clr) m_irq = 0;
    else if (bnd && m_sts && irq_en) m_irq = 1;
    if (uframe_tick) m_cnt = bnd ? eff : m_cnt - 1;
    if (cw && wdata[6]) m_door = 1;
    else if (m_clrp || !m_ase) m_door = 0;
    m_clrp = hit;
    if (hit) m_sts = 1;
    else if (clr) m_sts = 0;
    if (cw) begin
      m_thr = int'(wdata[23:16]);
      m_ase = wdata[5];
      m_pse = wdata[4];
    end
  endtask

  // One clock: model advances with the held inputs, then every output is compared
  task automatic cyc();
    @(posedge clk);
    #1;
    model_step();
    chk("R2 rdata", rdata, m_rd);
    chk("R3 async_en", 32'(async_en), 32'(m_ase));
    chk("R3 periodic_en", 32'(periodic_en), 32'(m_pse));
    chk("R5 adv_status", 32'(adv_status), 32'(m_sts));
    chk("R11 irq", 32'(irq), 32'(m_irq));
  endtask

  task automatic wr_cmd(logic [31:0] v);
    wr_en = 1; reg_sel = 0; wdata = v; cyc(); wr_en = 0; wdata = '0;
  endtask
  task automatic wr_sts(logic [31:0] v);
    wr_en = 1; reg_sel = 1; wdata = v; cyc(); wr_en = 0; wdata = '0; reg_sel = 0;
  endtask
  task automatic rd(logic sel);
    reg_sel = sel; cyc();
  endtask
  task automatic adv();
    adv_done = 1; cyc(); adv_done = 0;
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      uframe_tick = 1; cyc(); uframe_tick = 0; cyc();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst = 0;
    // R1 reset state
    rd(0); chk("R1 cmd reset", rdata, 32'h0008_0000);
    rd(1); chk("R1 sts reset", rdata, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 async_en", 32'(async_en), 32'h0);
    // R2 R3 R4 field behaviour
    wr_cmd(32'hFF02_FF30);
    rd(0); chk("R2 thr", rdata & 32'h00FF_0000, 32'h0002_0000);
    chk("R4 reserved", rdata & 32'hFF00_FF8F, 32'h0);
    chk("R3 async_en", 32'(async_en), 32'h1);
    chk("R3 periodic_en", 32'(periodic_en), 32'h1);
    // R5 doorbell ring, write of 0 does not clear
    wr_cmd(32'h0001_0060);
    rd(0); chk("R5 door set", rdata, 32'h0001_0060);
    wr_cmd(32'h0001_0020);
    rd(0); chk("R5 door kept", rdata, 32'h0001_0060);
    adv(); chk("R5 status posted", 32'(adv_status), 32'h1);
    rd(0); rd(0); chk("R5 door self-clear", rdata, 32'h0001_0020);
    // R10 interval 8 from reset still running: irq at 8th tick
    irq_en = 1;
    ticks(7); chk("R10 no irq before boundary", 32'(irq), 32'h0);
    ticks(1); chk("R10 irq at old boundary", 32'(irq), 32'h1);
    wr_sts(32'h0000_0020);
    chk("R8 status cleared", 32'(adv_status), 32'h0);
    chk("R11 irq dropped", 32'(irq), 32'h0);
    // R9 interval 1
    wr_cmd(32'h0001_0060); adv(); cyc(); cyc();
    chk("R11 no irq without boundary", 32'(irq), 32'h0);
    ticks(1); chk("R9 interval 1", 32'(irq), 32'h1);
    wr_sts(32'h0000_0020);
    // R9 invalid threshold falls back to 8
    wr_cmd(32'h0003_0020);
    rd(0); chk("R2 invalid readback", rdata, 32'h0003_0020);
    ticks(1);
    wr_cmd(32'h0003_0060); adv(); cyc(); cyc();
    ticks(7); chk("R9 invalid no early irq", 32'(irq), 32'h0);
    ticks(1); chk("R9 invalid interval 8", 32'(irq), 32'h1);
    wr_sts(32'h0000_0020);
    // R11 interrupt enable off
    irq_en = 0;
    wr_cmd(32'h0001_0060); adv(); cyc();
    ticks(9);
    chk("R11 masked irq", 32'(irq), 32'h0);
    chk("R11 status held", 32'(adv_status), 32'h1);
    wr_sts(32'h0000_0020);
    irq_en = 1;
    // R6 doorbell with async disabled
    wr_cmd(32'h0001_0040); cyc();
    rd(0); chk("R6 door dropped", rdata, 32'h0001_0000);
    adv(); cyc(); chk("R6 no status", 32'(adv_status), 32'h0);
    // R7 advance without doorbell
    wr_cmd(32'h0001_0020); adv(); cyc();
    chk("R7 no status", 32'(adv_status), 32'h0);
    // R8 set wins over clear
    wr_cmd(32'h0001_0060);
    adv_done = 1; wr_en = 1; reg_sel = 1; wdata = 32'h0000_0020;
    cyc();
    adv_done = 0; wr_en = 0; reg_sel = 0; wdata = '0;
    chk("R8 set wins", 32'(adv_status), 32'h1);
    ticks(1); cyc();
    wr_sts(32'hFFFF_FFFF);
    // R4 reserved bits on both words
    wr_cmd(32'hFFFF_FF8F);
    rd(0); chk("R4 cmd reserved", rdata, 32'h00FF_0000);
    rd(1); chk("R4 sts reserved", rdata, 32'h0);
    cyc();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule